// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single counter channel of an interval timer. A host programs it through byte-wide strobes. A control-byte strobe chooses the counting mode, binary or decimal counting and the byte transfer order, or it freezes the running count for readback. A data-byte strobe delivers the initial count. A separate count-enable pulse, `tick_en`, advances the channel. It is one clock cycle wide and is normally produced at a fixed rate elsewhere in the chip. The channel drives `wave_out` according to the selected mode. A rising edge on `gate_in` restarts counting in the modes that can be retriggered.

The byte ports carry register accesses, not a data stream. Each strobe is accepted in the cycle it is seen, so there is no valid/ready pair and no back-pressure. A control strobe wins over a data strobe in the same cycle, and the data strobe is then dropped. `rd_byte` always shows the byte the next read strobe will consume. Asserting `data_rd` moves the read sequence forward.

Top module: `interval_timer_ch`

## Requirements
- R1: An initial count of zero counts as 65536 in binary mode and as 10000 in decimal mode.
- R2: Control byte layout: bit 0 set selects decimal counting. Bits 3:1 give the mode, and codes 6 and 7 act as modes 2 and 3. Bits 5:4 give the access: 00 latch command, 01 low byte only, 10 high byte only, 11 low byte then high byte. Bits 7:6 are ignored. The count loads on the final data byte of the sequence, and a byte that is not written is zero.
- R3: In modes 0 and 1 the output is low from the load until the count of ticks reaches the initial count. It then goes high and stays high.
- R4: In mode 2 the output is high and goes low for exactly one tick at the end of every period of N ticks, where N is the initial count and N is at least 2.
- R5: In mode 3 each period of N ticks starts with (N+1)>>1 ticks high, and the output is low for the rest of the period.
- R6: In modes 4 and 5 the output is high, goes low for the single tick at which the tick count equals N, and then stays high.
- R7: A rising gate edge restarts counting from the initial count in modes 1, 2, 3 and 5. It has no effect in modes 0 and 4.
- R8: After reset the channel runs in mode 3, binary, word access, with an initial count of 65536 and the output high.
- R9: Loading a count restarts the tick count and readback from the new value. The output reflects the new count from the following cycle.
- R10: A latch command freezes the readback value. Reads return the frozen value until its last byte has been read. A second latch command while a value is held is ignored.
- R11: In decimal mode the readback counter decrements through four decimal digits and wraps from 0000 to 9999.
- R12: A control byte that is not a latch command stops counting until the next load. The output goes low in mode 0 and high in every other mode.
- R13: The readback counter decrements once per tick. It wraps from 0000 to FFFF in binary modes 0, 1, 4 and 5, and reloads the initial count at each period end in modes 2 and 3. Word reads return the low byte first, then the high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable pulse, one tick per high cycle |
| gate_in | input | 1 | Gate; a rising edge retriggers in modes 1, 2, 3 and 5 |
| ctrl_wr | input | 1 | Control-byte write strobe |
| data_wr | input | 1 | Count-byte write strobe |
| data_rd | input | 1 | Count-byte read strobe |
| wr_byte | input | 8 | Write data for both strobes |
| rd_byte | output | 8 | Byte the next read strobe returns |
| wave_out | output | 1 | Channel output waveform |

## Verification
Every input, tick or strobe, is captured at one rising edge. The channel's registers change at that edge, and both `wave_out` and `rd_byte` are combinational decodes of those registers. Each result is therefore due in the cycle that follows its stimulus. The bench drives inputs on falling edges and samples on the next falling edge. It holds `tick_en` high for exactly N cycles when it wants N ticks, so each expected waveform level or count is checked after an exact tick number. Readback is always taken with the tick pulse off, which keeps the count still while its bytes are read.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int DIGIT_W = 4;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } itc_mode_e;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } itc_acc_e;
endpackage

// File: rtl/itc_host_if.sv
module itc_host_if
  import itc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [CNT_W-1:0]  live_cnt,
  output itc_mode_e         mode_o,
  output logic              bcd_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              stop_o,
  output logic [BYTE_W-1:0] rd_byte
);
  itc_acc_e          acc_q;
  itc_mode_e         mode_q;
  logic              bcd_q, wr_hi_q, rd_hi_q, hold_vld_q;
  logic [BYTE_W-1:0] lo_q;
  logic [CNT_W-1:0]  hold_q;
  logic [2:0]        m_raw;
  itc_mode_e         m_dec;
  logic              cmd_latch, cmd_prog, wr_go, rd_go, rd_hi_sel;
  logic [CNT_W-1:0]  src;
  logic              unused_sel;

  assign unused_sel = ^wr_byte[BYTE_W-1:6];
  assign m_raw      = wr_byte[3:1];
  assign m_dec      = (m_raw[2] & m_raw[1]) ? itc_mode_e'({1'b0, m_raw[1:0]}) : itc_mode_e'(m_raw);
  assign cmd_latch  = ctrl_wr && (wr_byte[5:4] == 2'b00);
  assign cmd_prog   = ctrl_wr && !cmd_latch;
  assign wr_go      = data_wr && !ctrl_wr;
  assign rd_go      = data_rd && !ctrl_wr;

  assign stop_o = cmd_prog;
  assign load_o = wr_go && (acc_q != ACC_WORD || wr_hi_q);
  assign mode_o = mode_q;
  assign bcd_o  = bcd_q;

  always_comb begin
    case (acc_q)
      ACC_LO:  load_val_o = {{BYTE_W{1'b0}}, wr_byte};
      ACC_HI:  load_val_o = {wr_byte, {BYTE_W{1'b0}}};
      default: load_val_o = {wr_byte, lo_q};
    endcase
  end

  assign rd_hi_sel = (acc_q == ACC_HI) || (acc_q == ACC_WORD && rd_hi_q);
  assign src       = hold_vld_q ? hold_q : live_cnt;
  assign rd_byte   = rd_hi_sel ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= ACC_WORD;
      mode_q     <= M_SQUARE;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      lo_q       <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (cmd_prog) begin
      acc_q      <= itc_acc_e'(wr_byte[5:4]);
      mode_q     <= m_dec;
      bcd_q      <= wr_byte[0];
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      hold_vld_q <= 1'b0;
    end else begin
      if (cmd_latch && !hold_vld_q) begin
        hold_q     <= live_cnt;
        hold_vld_q <= 1'b1;
      end
      if (wr_go && acc_q == ACC_WORD) begin
        if (!wr_hi_q) lo_q <= wr_byte;
        wr_hi_q <= !wr_hi_q;
      end
      if (rd_go) begin
        if (acc_q == ACC_WORD && !rd_hi_q) rd_hi_q <= 1'b1;
        else begin
          rd_hi_q    <= 1'b0;
          hold_vld_q <= 1'b0;
        end
      end
    end
  end

  // R10: a held value never changes while it is held
  assert_hold_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld_q |=> $stable(hold_q));

  // R2: the first byte of a word write arms the high-byte step
  assert_word_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && acc_q == ACC_WORD && !wr_hi_q) |=> wr_hi_q);
endmodule

// File: rtl/itc_count_unit.sv
module itc_count_unit
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             retrig,
  input  logic             step,
  input  logic             wrap,
  input  logic             bcd,
  output logic [CNT_W-1:0] init_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int DIGITS = CNT_W / DIGIT_W;

  logic [CNT_W-1:0] init_q, cnt_q;

  function automatic logic [CNT_W-1:0] dec_dec(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic br;
    r  = v;
    br = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (br) begin
        if (v[DIGIT_W*i +: DIGIT_W] == '0) r[DIGIT_W*i +: DIGIT_W] = DIGIT_W'(9);
        else begin
          r[DIGIT_W*i +: DIGIT_W] = v[DIGIT_W*i +: DIGIT_W] - DIGIT_W'(1);
          br = 1'b0;
        end
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      init_q <= load_val;
      cnt_q  <= load_val;
    end else if (retrig) begin
      cnt_q <= init_q;
    end else if (step) begin
      if (wrap)     cnt_q <= init_q;
      else if (bcd) cnt_q <= dec_dec(cnt_q);
      else          cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign init_o = init_q;
  assign cnt_o  = cnt_q;

  // R9: a load shows up in the readback on the next cycle
  assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R13: binary readback wraps from zero to all ones
  assert_bin_wrap_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !retrig && !wrap && !bcd && cnt_q == '0) |=> (cnt_q == '1));
endmodule

// File: rtl/itc_wave_gen.sv
module itc_wave_gen
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate_rise,
  input  logic             load,
  input  logic             stop,
  input  itc_mode_e        mode,
  input  logic             bcd,
  input  logic [CNT_W-1:0] init_cnt,
  output logic             wave,
  output logic             step,
  output logic             wrap,
  output logic             retrig
);
  localparam int PW     = CNT_W + 1;
  localparam int DIGITS = CNT_W / DIGIT_W;

  function automatic logic [PW-1:0] pow10(input int n);
    logic [PW-1:0] p;
    p = PW'(1);
    for (int i = 0; i < n; i++) p = p * PW'(10);
    return p;
  endfunction

  function automatic logic [PW-1:0] to_bin(input logic [CNT_W-1:0] v);
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = DIGITS - 1; i >= 0; i--)
      acc = acc * PW'(10) + PW'(v[DIGIT_W*i +: DIGIT_W]);
    return acc;
  endfunction

  localparam logic [PW-1:0] BCD_FULL = pow10(DIGITS);
  localparam logic [PW-1:0] BIN_FULL = PW'(1) << CNT_W;

  logic [PW-1:0] per, half, e_q;
  logic          running_q, started_q, restart, retrig_mode, periodic;

  always_comb begin
    if (init_cnt == '0) per = bcd ? BCD_FULL : BIN_FULL;
    else                per = bcd ? to_bin(init_cnt) : PW'(init_cnt);
  end
  assign half = (per + PW'(1)) >> 1;

  assign retrig_mode = (mode == M_ONESHOT) || (mode == M_RATE) ||
                       (mode == M_SQUARE)  || (mode == M_HWSTROBE);
  assign periodic    = (mode == M_RATE) || (mode == M_SQUARE);
  assign retrig      = gate_rise && running_q && retrig_mode && !stop;
  assign restart     = load || retrig;
  assign step        = tick && running_q && !stop;
  assign wrap        = step && periodic && (e_q == per - PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b1;
      started_q <= 1'b0;
      e_q       <= '0;
    end else if (stop) begin
      running_q <= 1'b0;
    end else if (restart) begin
      running_q <= 1'b1;
      started_q <= 1'b0;
      e_q       <= '0;
    end else if (step) begin
      started_q <= 1'b1;
      case (mode)
        M_TERM, M_ONESHOT: if (e_q < per) e_q <= e_q + PW'(1);
        M_RATE, M_SQUARE:  e_q <= wrap ? '0 : e_q + PW'(1);
        default:           if (e_q <= per) e_q <= e_q + PW'(1);
      endcase
    end
  end

  always_comb begin
    if (!running_q) wave = (mode != M_TERM);
    else begin
      case (mode)
        M_TERM, M_ONESHOT: wave = (e_q >= per);
        M_RATE:            wave = !(e_q == '0 && started_q);
        M_SQUARE:          wave = (e_q < half);
        default:           wave = (e_q != per);
      endcase
    end
  end

  // R3: once high in modes 0 and 1, the output holds until restart or stop
  assert_term_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && (mode == M_TERM || mode == M_ONESHOT) && wave && !restart && !stop) |=> wave);

  // R4: the mode 2 low strobe lasts a single tick
  assert_rate_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && mode == M_RATE && per > PW'(1) && !wave && step && !restart) |=> wave);

  // R6: the mode 4/5 strobe ends on the next tick
  assert_strobe_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && (mode == M_SWSTROBE || mode == M_HWSTROBE) && !wave && step && !restart) |=> wave);

  // R12: a stopped channel keeps its elapsed count
  assert_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !restart) |=> $stable(e_q));
endmodule

// File: rtl/interval_timer_ch.sv
module interval_timer_ch
  import itc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              gate_in,
  input  logic              ctrl_wr,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              wave_out
);
  localparam int CNT_W = 2 * BYTE_W;

  itc_mode_e        mode;
  logic             bcd, load, stop, step, wrap, retrig, gate_q, gate_rise;
  logic [CNT_W-1:0] load_val, init_cnt, live_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= gate_in;
  end
  assign gate_rise = gate_in && !gate_q;

  itc_host_if #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) host_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .data_wr(data_wr), .data_rd(data_rd),
    .wr_byte(wr_byte), .live_cnt(live_cnt), .mode_o(mode), .bcd_o(bcd), .load_o(load),
    .load_val_o(load_val), .stop_o(stop), .rd_byte(rd_byte)
  );

  itc_count_unit #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .retrig(retrig),
    .step(step), .wrap(wrap), .bcd(bcd), .init_o(init_cnt), .cnt_o(live_cnt)
  );

  itc_wave_gen #(.CNT_W(CNT_W)) wave_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .gate_rise(gate_rise), .load(load),
    .stop(stop), .mode(mode), .bcd(bcd), .init_cnt(init_cnt), .wave(wave_out),
    .step(step), .wrap(wrap), .retrig(retrig)
  );
endmodule

// File: tb/interval_timer_ch_tb.sv
module interval_timer_ch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int NROWS      = 18;

  // {req, ctrl, count, ticks, exp_out, exp_readback}
  localparam logic [63:0] VEC [0:NROWS-1] = '{
    {8'd3,  8'h30, 16'h0005, 8'd4, 8'd0, 16'h0001}, // R3 mode 0 before terminal
    {8'd3,  8'h30, 16'h0005, 8'd5, 8'd1, 16'h0000}, // R3 mode 0 at terminal
    {8'd13, 8'h30, 16'h0005, 8'd7, 8'd1, 16'hFFFE}, // R13 binary wrap
    {8'd4,  8'h34, 16'h0004, 8'd3, 8'd1, 16'h0001}, // R4
    {8'd4,  8'h34, 16'h0004, 8'd4, 8'd0, 16'h0004}, // R4 strobe and reload
    {8'd4,  8'h34, 16'h0004, 8'd5, 8'd1, 16'h0003}, // R4
    {8'd5,  8'h36, 16'h0005, 8'd2, 8'd1, 16'h0003}, // R5 odd count
    {8'd5,  8'h36, 16'h0005, 8'd3, 8'd0, 16'h0002}, // R5
    {8'd5,  8'h36, 16'h0005, 8'd5, 8'd1, 16'h0005}, // R5 second period
    {8'd5,  8'h36, 16'h0005, 8'd8, 8'd0, 16'h0002}, // R5
    {8'd6,  8'h38, 16'h0003, 8'd2, 8'd1, 16'h0001}, // R6
    {8'd6,  8'h38, 16'h0003, 8'd3, 8'd0, 16'h0000}, // R6 strobe
    {8'd6,  8'h38, 16'h0003, 8'd4, 8'd1, 16'hFFFF}, // R6 after strobe
    {8'd11, 8'h31, 16'h0002, 8'd3, 8'd1, 16'h9999}, // R11 decimal wrap
    {8'd3,  8'h32, 16'h0002, 8'd2, 8'd1, 16'h0000}, // R3 mode 1
    {8'd6,  8'h3A, 16'h0002, 8'd2, 8'd0, 16'h0000}, // R6 mode 5
    {8'd2,  8'h3E, 16'h0004, 8'd2, 8'd0, 16'h0002}, // R2 code 7 acts as mode 3
    {8'd11, 8'h37, 16'h0010, 8'd5, 8'd0, 16'h0005}  // R11 decimal square
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, gate_in = 1'b0;
  logic       ctrl_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] wr_byte = '0;
  logic [7:0] rd_byte;
  logic       wave_out;
  int         ntot = 0, nbad = 0;
  logic [7:0] b0, b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  interval_timer_ch dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_in(gate_in), .ctrl_wr(ctrl_wr),
    .data_wr(data_wr), .data_rd(data_rd), .wr_byte(wr_byte), .rd_byte(rd_byte), .wave_out(wave_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    wr_byte = v; ctrl_wr = 1'b1;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    wr_byte = v; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    v = rd_byte; data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic gate_pulse();
    gate_in = 1'b1; @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    ntot++; nbad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state: mode 3, count 65536, output high
    chk("R8 reset out", {15'd0, wave_out}, 16'd1);
    rd(b0); rd(b1);
    chk("R8 reset readback", {b1, b0}, 16'h0000);
    // R1 zero means 65536: high half is 32768 ticks
    ticks(32767);
    chk("R1 half minus one", {15'd0, wave_out}, 16'd1);
    ticks(1);
    chk("R1 half reached", {15'd0, wave_out}, 16'd0);
    rd(b0); rd(b1);
    chk("R13 live readback", {b1, b0}, 16'h8000);

    // Table walk
    for (int i = 0; i < NROWS; i++) begin
      logic [63:0] v;
      v = VEC[i];
      wr_ctrl(v[55:48]);
      wr_data(v[39:32]);
      wr_data(v[47:40]);
      ticks(int'(v[31:24]));
      chk($sformatf("R%0d row %0d out", v[63:56], i), {15'd0, wave_out}, {8'd0, v[23:16]} & 16'd1);
      wr_ctrl(8'h00);
      rd(b0); rd(b1);
      chk($sformatf("R%0d row %0d count", v[63:56], i), {b1, b0}, v[15:0]);
    end

    // R2 low byte only
    wr_ctrl(8'h10); wr_data(8'h07);
    ticks(6); chk("R2 lo-only before", {15'd0, wave_out}, 16'd0);
    ticks(1); chk("R2 lo-only at count", {15'd0, wave_out}, 16'd1);

    // R2 high byte only: count 0x0100
    wr_ctrl(8'h20); wr_data(8'h01);
    ticks(255); chk("R2 hi-only before", {15'd0, wave_out}, 16'd0);
    ticks(1);   chk("R2 hi-only at count", {15'd0, wave_out}, 16'd1);
    wr_ctrl(8'h00); rd(b0);
    chk("R2 hi-only latched byte", {8'd0, b0}, 16'h0000);
    ticks(1); rd(b0);
    chk("R13 hi-only live byte", {8'd0, b0}, 16'h00FF);

    // R12 control write stops counting, level per mode
    wr_ctrl(8'h34); wr_data(8'h04); wr_data(8'h00);
    ticks(2);
    wr_ctrl(8'h34);
    chk("R12 stop level mode 2", {15'd0, wave_out}, 16'd1);
    ticks(5);
    chk("R12 stopped level", {15'd0, wave_out}, 16'd1);
    wr_ctrl(8'h00); rd(b0); rd(b1);
    chk("R12 count frozen", {b1, b0}, 16'h0002);
    wr_ctrl(8'h30);
    chk("R12 stop level mode 0", {15'd0, wave_out}, 16'd0);
    ticks(10);
    chk("R12 mode 0 stays low", {15'd0, wave_out}, 16'd0);

    // R9 reload while running
    wr_ctrl(8'h30); wr_data(8'h0A); wr_data(8'h00);
    ticks(5);
    wr_data(8'h03); wr_data(8'h00);
    chk("R9 out after reload", {15'd0, wave_out}, 16'd0);
    wr_ctrl(8'h00); rd(b0); rd(b1);
    chk("R9 readback after reload", {b1, b0}, 16'h0003);
    ticks(3);
    chk("R9 terminal of new count", {15'd0, wave_out}, 16'd1);

    // R7 retrigger in mode 1
    wr_ctrl(8'h32); wr_data(8'h04); wr_data(8'h00);
    ticks(2); gate_pulse();
    ticks(3); chk("R7 mode 1 restarted", {15'd0, wave_out}, 16'd0);
    ticks(1); chk("R7 mode 1 terminal", {15'd0, wave_out}, 16'd1);
    gate_in = 1'b0; @(negedge clk);

    // R7 gate ignored in mode 0
    wr_ctrl(8'h30); wr_data(8'h04); wr_data(8'h00);
    ticks(2); gate_pulse();
    ticks(2); chk("R7 mode 0 ignores gate", {15'd0, wave_out}, 16'd1);
    gate_in = 1'b0; @(negedge clk);

    // R10 latch holds across ticks and reads
    wr_ctrl(8'h30); wr_data(8'h64); wr_data(8'h00);
    ticks(10); wr_ctrl(8'h00);
    ticks(5); rd(b0);
    chk("R10 held low byte", {8'd0, b0}, 16'h005A);
    ticks(3); rd(b1);
    chk("R10 held high byte", {8'd0, b1}, 16'h0000);
    rd(b0); rd(b1);
    chk("R10 live after release", {b1, b0}, 16'h0052);
    wr_ctrl(8'h00); ticks(2); wr_ctrl(8'h00);
    rd(b0); rd(b1);
    chk("R10 second latch ignored", {b1, b0}, 16'h0052);

    // R1 / R11 decimal zero means 10000
    wr_ctrl(8'h31); wr_data(8'h00); wr_data(8'h00);
    ticks(1); wr_ctrl(8'h00); rd(b0); rd(b1);
    chk("R11 decimal from zero", {b1, b0}, 16'h9999);
    ticks(9998);
    chk("R1 decimal before 10000", {15'd0, wave_out}, 16'd0);
    ticks(1);
    chk("R1 decimal at 10000", {15'd0, wave_out}, 16'd1);

    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule